// File: doc/BRIEF.md
# Tagged HDLC Frame Encoder

This block turns bytes written by a microcontroller into a serial HDLC bit stream. The controller writes each byte into a small transmit queue at one of four register addresses, and the low two address bits become a tag that is stored with the byte. When the serialiser takes an entry from the queue, the tag decides how the byte is sent. It can be payload data, which is zero-bit stuffed and added to a running CRC. It can be a request to send one byte of the CRC. It can be a raw byte such as a flag, sent without stuffing. The last choice is a raw byte that also restarts the CRC.

Each pulse of a bit-clock enable sends one line bit, and a valid strobe marks it one cycle later. While the queue is empty, the serialiser sends the flag byte 0x7E again and again, so the line always carries idle flags between frames. The queue's empty flag, full flag and fill level are brought out as status ports. The controller sees the block as a window of sixteen byte registers. Only the four lowest addresses load the queue.

Top module: `hdlc_tagged_encoder`

## Requirements
- R1: After reset, fifo_empty is 1, fifo_full is 0, fifo_level is 0 and tx_valid is 0.
- R2: A write to address 0, 1, 2 or 3 queues wr_data with tag = wr_addr[1:0] (0 payload, 1 CRC byte, 2 raw, 3 raw with CRC restart). A write to any address from 4 to 15 leaves fifo_level and the bit stream unchanged.
- R3: The queue holds 32 entries. fifo_full is 1 when fifo_level is 32. A write arriving while the queue is full is dropped and never reaches the line.
- R4: Each cycle with bit_en high produces exactly one line bit, presented on tx_bit with tx_valid high in the following cycle. The bits of every byte go out least significant first.
- R5: While the queue holds no entry, the line carries the raw byte 0x7E back to back. An entry that is already waiting is sent right after the byte currently in progress.
- R6: Bits from payload bytes and CRC bytes are stuffed: after five consecutive 1s, a 0 is inserted before the next bit is sent.
- R7: The CRC uses the 16-bit polynomial x^16+x^12+x^5+1, bit-reflected, and is updated LSB first by payload bits only. The first tag-1 entry sends the complement of its low byte and the second sends the complement of its high byte. The data written with tag 1 is ignored. For the payload "123456789" with the CRC restarted, the bytes sent are 0x6E and then 0x90.
- R8: Raw bytes (tag 2 and tag 3) are sent without stuffing and clear the count of consecutive 1s. If five 1s have just been sent from stuffed data, the pending 0 is still sent before the raw byte.
- R9: A tag-3 entry restarts the CRC at all ones, so two frames each opened by a tag-3 flag give identical CRC bytes for identical payloads.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W (4) | Register address; addresses 0..3 load the queue with tag = low two bits |
| wr_data | input | 8 | Byte written |
| bit_en | input | 1 | Bit-clock enable; one line bit per high cycle |
| tx_bit | output | 1 | Serial line bit |
| tx_valid | output | 1 | High for one cycle when tx_bit holds a new bit |
| fifo_empty | output | 1 | Status: queue holds no entry |
| fifo_full | output | 1 | Status: queue holds DEPTH entries |
| fifo_level | output | clog2(DEPTH+1) (6) | Status: number of queued entries |

## Verification
If the stuffing run count is wrong, the error shows up within a few bits. A 0 is missing or extra after a run of 1s, or a raw flag is corrupted by a stuff bit. The bit offset of every later bit then shifts by one, so every later byte in the captured stream is misaligned. A CRC register that is restarted, updated or split into bytes wrongly only shows up when the tag-1 bytes go out at the end of the frame. These bytes are compared against the known value for "123456789". A fault in the queue pointers or the fill count shows at once on fifo_level, and a frame drawn from such a queue carries lost or repeated bytes.

// File: rtl/hdlc_enc_pkg.sv
package hdlc_enc_pkg;

    typedef enum logic [1:0] {
        TAG_DATA     = 2'b00,
        TAG_FCS      = 2'b01,
        TAG_RAW      = 2'b10,
        TAG_RAW_INIT = 2'b11
    } tag_e;

    typedef struct packed {
        tag_e       tag;
        logic [7:0] data;
    } entry_t;

    localparam logic [7:0]  FLAG_BYTE     = 8'h7E;
    localparam logic [15:0] CRC_INIT      = 16'hFFFF;
    localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
    localparam int          RUN_LIMIT     = 5;

    // One LSB-first step of the reflected CCITT CRC.
    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[0] ^ b;
        return fb ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    endfunction

    function automatic logic is_stuffed(input tag_e t);
        return (t == TAG_DATA) || (t == TAG_FCS);
    endfunction

endpackage

// File: rtl/hdlc_reg_decode.sv
module hdlc_reg_decode
    import hdlc_enc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    output logic              push,
    output entry_t            entry
);
    // Queue window: every address whose bits above bit 1 are zero.
    logic in_window;

    always_comb begin
        in_window  = (wr_addr[ADDR_W-1:2] == '0);
        push       = wr_en && in_window;
        entry.tag  = tag_e'(wr_addr[1:0]);
        entry.data = wr_data;
    end

endmodule

// File: rtl/hdlc_tx_fifo.sv
module hdlc_tx_fifo
    import hdlc_enc_pkg::*;
#(
    parameter  int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  entry_t           din,
    input  logic             pop,
    output entry_t           dout,
    output logic             empty,
    output logic             full,
    output logic [LVL_W-1:0] level
);
    entry_t           mem [DEPTH];
    logic [PTR_W-1:0] wp, rp;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        empty   = (level == '0);
        full    = (level == LVL_W'(DEPTH));
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            if (do_push && !do_pop)      level <= level + 1'b1;
            else if (do_pop && !do_push) level <= level - 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_bit_serializer.sv
module hdlc_bit_serializer
    import hdlc_enc_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   bit_en,
    input  entry_t head,
    input  logic   head_valid,
    output logic   pop,
    output logic   tx_bit,
    output logic   tx_valid
);
    logic        loaded;
    tag_e        cur_tag;
    logic [7:0]  shreg;
    logic [2:0]  idx;
    logic [2:0]  ones;
    logic [15:0] crc;
    logic        fcs_hi;

    logic        stuff_now, emit_data, fetch;
    logic [15:0] crc_nx;
    entry_t      nxt;
    logic [7:0]  load_byte;

    always_comb begin
        stuff_now = bit_en && loaded && (ones == 3'(RUN_LIMIT));
        emit_data = bit_en && loaded && !stuff_now;
        fetch     = !loaded || (emit_data && idx == 3'd7);
        pop       = fetch && head_valid;
        nxt       = head_valid ? head : '{tag: TAG_RAW, data: FLAG_BYTE};
        crc_nx    = (emit_data && cur_tag == TAG_DATA) ? crc_step(crc, shreg[0]) : crc;
        if (nxt.tag == TAG_FCS) load_byte = fcs_hi ? ~crc_nx[15:8] : ~crc_nx[7:0];
        else                    load_byte = nxt.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            loaded   <= 1'b0;
            cur_tag  <= TAG_RAW;
            shreg    <= '0;
            idx      <= '0;
            ones     <= '0;
            crc      <= CRC_INIT;
            fcs_hi   <= 1'b0;
            tx_bit   <= 1'b0;
            tx_valid <= 1'b0;
        end else begin
            tx_valid <= stuff_now || emit_data;
            crc      <= crc_nx;
            if (stuff_now) begin
                tx_bit <= 1'b0;
                ones   <= '0;
            end
            if (emit_data) begin
                tx_bit <= shreg[0];
                shreg  <= {1'b0, shreg[7:1]};
                idx    <= idx + 1'b1;
                if (is_stuffed(cur_tag) && shreg[0]) ones <= ones + 1'b1;
                else                                 ones <= '0;
            end
            if (fetch) begin
                loaded  <= 1'b1;
                idx     <= '0;
                cur_tag <= nxt.tag;
                shreg   <= load_byte;
                fcs_hi  <= (nxt.tag == TAG_FCS) ? !fcs_hi : 1'b0;
                if (nxt.tag == TAG_RAW_INIT) crc <= CRC_INIT;
            end
        end
    end

endmodule

// File: rtl/hdlc_tagged_encoder.sv
module hdlc_tagged_encoder
    import hdlc_enc_pkg::*;
#(
    parameter  int DEPTH  = 32,
    parameter  int ADDR_W = 4,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              bit_en,
    output logic              tx_bit,
    output logic              tx_valid,
    output logic              fifo_empty,
    output logic              fifo_full,
    output logic [LVL_W-1:0]  fifo_level
);
    entry_t wr_entry, head;
    logic   fifo_push, fifo_pop, head_valid;

    assign head_valid = !fifo_empty;

    hdlc_reg_decode #(.ADDR_W(ADDR_W)) u_dec (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .push    (fifo_push),
        .entry   (wr_entry)
    );

    hdlc_tx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (fifo_push),
        .din   (wr_entry),
        .pop   (fifo_pop),
        .dout  (head),
        .empty (fifo_empty),
        .full  (fifo_full),
        .level (fifo_level)
    );

    hdlc_bit_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .bit_en     (bit_en),
        .head       (head),
        .head_valid (head_valid),
        .pop        (fifo_pop),
        .tx_bit     (tx_bit),
        .tx_valid   (tx_valid)
    );

endmodule

// File: rtl/hdlc_tagged_encoder_chk.sv
module hdlc_tagged_encoder_chk #(
    parameter  int DEPTH  = 32,
    parameter  int ADDR_W = 4,
    localparam int LVL_W  = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic              bit_en,
    input logic              tx_valid,
    input logic              fifo_empty,
    input logic              fifo_full,
    input logic [LVL_W-1:0]  fifo_level,
    input logic              fifo_pop
);
    logic in_window;
    assign in_window = (wr_addr[ADDR_W-1:2] == '0);

    p_empty_full_excl_r1: assert property (@(posedge clk) disable iff (rst)
        !(fifo_empty && fifo_full));

    p_ignored_addr_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !in_window && !fifo_pop) |=> $stable(fifo_level));

    p_push_counts_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_window && !fifo_full && !fifo_pop)
        |=> fifo_level == LVL_W'($past(fifo_level) + 1'b1));

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && !fifo_pop) |=> fifo_full);

    p_level_bound_r3: assert property (@(posedge clk) disable iff (rst)
        fifo_level <= LVL_W'(DEPTH));

    p_valid_after_en_r4: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(bit_en));

endmodule

bind hdlc_tagged_encoder hdlc_tagged_encoder_chk #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .bit_en     (bit_en),
    .tx_valid   (tx_valid),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .fifo_level (fifo_level),
    .fifo_pop   (fifo_pop)
);

// File: tb/hdlc_tagged_encoder_bench.sv
module hdlc_tagged_encoder_bench;

    localparam int DEPTH  = 32;
    localparam int ADDR_W = 4;
    localparam int LVL_W  = $clog2(DEPTH + 1);
    localparam int CAPMAX = 1024;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic              bit_en = 1'b0;
    logic              tx_bit, tx_valid, fifo_empty, fifo_full;
    logic [LVL_W-1:0]  fifo_level;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    logic cap   [CAPMAX];
    logic exp_b [CAPMAX];
    int   cap_n = 0;
    int   exp_n = 0;
    int   m_ones = 0;

    always #4 clk = ~clk;   // 125 MHz

    hdlc_tagged_encoder #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_hdlc_tagged_encoder (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .bit_en(bit_en), .tx_bit(tx_bit), .tx_valid(tx_valid),
        .fifo_empty(fifo_empty), .fifo_full(fifo_full), .fifo_level(fifo_level)
    );

    always @(negedge clk) begin
        if (!rst && tx_valid && cap_n < CAPMAX) begin
            cap[cap_n] = tx_bit;
            cap_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    // Expected line model built from the requirements.
    task automatic e_bit(input logic b);
        exp_b[exp_n] = b;
        exp_n++;
    endtask

    task automatic e_raw(input logic [7:0] d);
        if (m_ones == 5) e_bit(1'b0);
        m_ones = 0;
        for (int i = 0; i < 8; i++) e_bit(d[i]);
    endtask

    task automatic e_stf(input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            if (m_ones == 5) begin
                e_bit(1'b0);
                m_ones = 0;
            end
            e_bit(d[i]);
            m_ones = d[i] ? m_ones + 1 : 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        bit_en = 1'b0;
        wr_en  = 1'b0;
        rst    = 1'b1;
        repeat (3) @(negedge clk);
        rst    = 1'b0;
        @(negedge clk);
        cap_n  = 0;
        exp_n  = 0;
        m_ones = 0;
        e_raw(8'h7E);   // flag already in flight after reset
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic run_bits(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            bit_en = 1'b1;
            @(negedge clk);
            bit_en = 1'b0;
            repeat (2) @(negedge clk);
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic check_stream(input string req);
        int bad;
        int first;
        bad   = 0;
        first = -1;
        for (int i = 0; i < exp_n; i++) begin
            if (i >= cap_n || cap[i] !== exp_b[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        if (bad != 0)
            chk(1'b0, $sformatf("%s stream bit %0d", req, first),
                (first < cap_n) ? int'(cap[first]) : -1, int'(exp_b[first]));
        else
            chk(1'b1, req, 0, 0);
    endtask

    task automatic t_reset();
        do_reset();
        chk(fifo_empty === 1'b1, "R1 empty", int'(fifo_empty), 1);
        chk(fifo_full === 1'b0, "R1 full", int'(fifo_full), 0);
        chk(fifo_level === '0, "R1 level", int'(fifo_level), 0);
        chk(tx_valid === 1'b0, "R1 tx_valid", int'(tx_valid), 0);
    endtask

    task automatic t_timing();
        do_reset();
        @(negedge clk);
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        chk(tx_valid === 1'b1, "R4 valid one cycle after bit_en", int'(tx_valid), 1);
        chk(tx_bit === 1'b0, "R4 first bit is flag LSB", int'(tx_bit), 0);
        @(negedge clk);
        chk(tx_valid === 1'b0, "R4 valid single cycle", int'(tx_valid), 0);
    endtask

    task automatic t_idle();
        do_reset();
        e_raw(8'h7E);
        e_raw(8'h7E);
        run_bits(exp_n);
        check_stream("R5 idle flags");
    endtask

    task automatic t_frame_crc();
        do_reset();
        wr(4'd3, 8'h7E);
        for (int i = 0; i < 9; i++) wr(4'd0, 8'h31 + 8'(i));
        wr(4'd1, 8'h55);   // data ignored
        wr(4'd1, 8'hA3);
        wr(4'd2, 8'h7E);
        e_raw(8'h7E);
        for (int i = 0; i < 9; i++) e_stf(8'h31 + 8'(i));
        e_stf(8'h6E);
        e_stf(8'h90);
        e_raw(8'h7E);
        run_bits(exp_n);
        check_stream("R7 frame with CRC 6E 90");
    endtask

    task automatic t_crc_restart();
        do_reset();
        for (int f = 0; f < 2; f++) begin
            wr(4'd3, 8'h7E);
            for (int i = 0; i < 9; i++) wr(4'd0, 8'h31 + 8'(i));
            wr(4'd1, 8'h00);
            wr(4'd1, 8'h00);
            e_raw(8'h7E);
            for (int i = 0; i < 9; i++) e_stf(8'h31 + 8'(i));
            e_stf(8'h6E);
            e_stf(8'h90);
        end
        wr(4'd2, 8'h7E);
        e_raw(8'h7E);
        run_bits(exp_n);
        check_stream("R9 second frame CRC after tag-3 restart");
    endtask

    task automatic t_stuff();
        int bad;
        do_reset();
        wr(4'd3, 8'h7E);
        wr(4'd0, 8'hFF);
        wr(4'd0, 8'hFF);
        wr(4'd2, 8'h7E);
        e_raw(8'h7E);
        e_stf(8'hFF);
        e_stf(8'hFF);
        e_raw(8'h7E);
        run_bits(exp_n);
        check_stream("R6 stuffing of 0xFF 0xFF");
        bad = 0;
        for (int i = 0; i < 19; i++)
            if (cap[16 + i] !== ((i == 5 || i == 11 || i == 17) ? 1'b0 : 1'b1)) bad++;
        chk(bad == 0, "R6 zeros after each five ones", bad, 0);
    endtask

    task automatic t_pending_stuff();
        do_reset();
        wr(4'd3, 8'h7E);
        wr(4'd0, 8'hF8);   // ends with five 1s
        wr(4'd2, 8'h7E);
        e_raw(8'h7E);
        e_stf(8'hF8);
        e_raw(8'h7E);      // 0 inserted before it
        run_bits(exp_n);
        check_stream("R8 pending stuff before raw flag");
        chk(cap[24] === 1'b0 && cap[25] === 1'b0, "R8 stuff bit before flag",
            int'(cap[24]), 0);
    endtask

    task automatic t_raw_ff();
        do_reset();
        wr(4'd2, 8'hFF);
        wr(4'd2, 8'hFF);
        e_raw(8'hFF);
        e_raw(8'hFF);
        e_raw(8'h7E);
        run_bits(exp_n);
        check_stream("R8 raw 0xFF not stuffed");
    endtask

    task automatic t_ignored_addr();
        do_reset();
        wr(4'd5, 8'h12);
        wr(4'd15, 8'h34);
        wr(4'd4, 8'h56);
        chk(fifo_level === '0, "R2 addresses 4..15 ignored", int'(fifo_level), 0);
        wr(4'd2, 8'hC3);
        chk(fifo_level === LVL_W'(1), "R2 address 2 queues", int'(fifo_level), 1);
        e_raw(8'hC3);
        e_raw(8'h7E);
        run_bits(exp_n);
        check_stream("R2 only window write reaches line");
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH + 1; i++) wr(4'd2, 8'(i));
        chk(fifo_level === LVL_W'(DEPTH), "R3 level at capacity", int'(fifo_level), DEPTH);
        chk(fifo_full === 1'b1, "R3 full flag", int'(fifo_full), 1);
        for (int i = 0; i < DEPTH; i++) e_raw(8'(i));
        e_raw(8'h7E);
        run_bits(exp_n);
        check_stream("R3 extra write dropped");
        chk(fifo_empty === 1'b1, "R3 drained", int'(fifo_empty), 1);
    endtask

    initial begin
        t_reset();
        t_timing();
        t_idle();
        t_frame_crc();
        t_crc_restart();
        t_stuff();
        t_pending_stuff();
        t_raw_ff();
        t_ignored_addr();
        t_full();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule